// File: doc/BRIEF.md
# Dual-Port Packet Router with Hit Counter

The block sits between two input packet queues and two sinks. On every cycle it looks at the packet at the head of each input. Bit 0 of the packet picks the output queue for that packet. When the output queue has room, the block moves the packet into it. Moving a packet and removing it from its input happen in the same cycle: the input's ready strobe is the dequeue. Each output queue is a small FIFO that offers its head packet to the sink through a valid/ready handshake.

Input A has priority over input B. The routing decision is made separately for each destination. When A and B head for different outputs and both outputs have room, both packets move in the same cycle. When they head for the same output, A takes it and B waits. Bit 1 of a packet marks it as interesting. A wrapping counter adds the number of interesting packets moved in a cycle, which is zero, one or two.

The asynchronous active-low reset is released through a two-stage synchronizer. The block accepts traffic from the second rising edge after the reset input goes high.

Top module: `pkr_router`

## Requirements
- R1: While reset is active, and for the cycles until it has been released internally, both output valids are low, the hit counter reads 0, and neither input ready is high, even when an input presents a valid packet.
- R2: A packet with bit 0 equal to 1 is delivered on output 1 (`o1_*`), and a packet with bit 0 equal to 0 is delivered on output 2 (`o2_*`). Its 16 bits are unchanged. Each output delivers its packets in the order they were accepted.
- R3: An input's ready is high in exactly the cycles in which its valid packet is accepted. The accepted packet appears at its output's head (valid high) from the next cycle at the earliest.
- R4: When A and B are both valid and target the same output, B's ready is low in that cycle. A is accepted if that output has room.
- R5: When A and B are both valid, target different outputs, and both of those outputs have room, both readies are high in the same cycle.
- R6: Whether an input is accepted depends only on the room in its own target output. A full output does not block a packet bound for the other output.
- R7: Each output FIFO holds 4 packets. A packet whose output holds 4 is not accepted: its ready stays low and it stays at its input. No packet is dropped or duplicated.
- R8: The hit counter adds, on each clock, the number of accepted packets whose bit 1 is 1. It wraps modulo 2^CNT_W and is otherwise unchanged.
- R9: An output's valid is high exactly while its FIFO holds a packet. While valid is high and ready is low, the offered packet stays the same. A packet leaves the FIFO on a cycle with both valid and ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Input A head packet present (priority input) |
| a_data | input | 16 | Input A head packet |
| a_ready | output | 1 | Input A packet accepted and dequeued this cycle |
| b_valid | input | 1 | Input B head packet present |
| b_data | input | 16 | Input B head packet |
| b_ready | output | 1 | Input B packet accepted and dequeued this cycle |
| o1_valid | output | 1 | Output 1 FIFO holds a packet |
| o1_data | output | 16 | Output 1 head packet |
| o1_ready | input | 1 | Sink takes output 1 head |
| o2_valid | output | 1 | Output 2 FIFO holds a packet |
| o2_data | output | 16 | Output 2 head packet |
| o2_ready | input | 1 | Sink takes output 2 head |
| hit_count | output | 16 | Running count of interesting packets moved |

## Verification
Assertions check on every cycle the following properties:
- A FIFO is never written while full.
- A stalled head packet stays stable.
- Two grants in one cycle never target the same output.
- B is refused on a clash with A.
- The counter holds when no packet moves.
- An accepted packet makes its output valid on the next cycle.

Other properties need the bench's reference queues and reference count, kept over long runs:
- Packets are routed correctly with their data intact.
- No packet is lost or repeated.
- Order is kept within each output.
- The counter adds two in one cycle and wraps correctly.
- A full output does not block traffic bound for the other output.

The bench runs these checks under sink stall patterns and input patterns that sweep every combination of destination and flag.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

  typedef enum logic {
    SEL_O1 = 1'b0,
    SEL_O2 = 1'b1
  } osel_e;

  // destination bit set -> output 1, clear -> output 2
  function automatic osel_e pick_out(input logic dest_bit);
    return dest_bit ? SEL_O1 : SEL_O2;
  endfunction

endpackage

// File: rtl/pkr_fifo.sv
module pkr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_vld,
  output logic [W-1:0] out_data,
  input  logic         out_rdy
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;

  assign full     = (cnt_q == CAP);
  assign out_vld  = (cnt_q != '0);
  assign out_data = mem[rp_q];
  assign wr_en    = push && !full;
  assign rd_en    = out_vld && out_rdy;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_en) wp_d = (wp_q == LAST) ? '0 : wp_q + AW'(1);
    if (rd_en) rp_d = (rp_q == LAST) ? '0 : rp_q + AW'(1);
    cnt_d = cnt_q + CW'(wr_en) - CW'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_d;
      if (rd_en) rp_q <= rp_d;
      if (wr_en || rd_en) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= push_data;
  end

  // R7: the router never writes a full queue
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: stalled head is held
  a_r9_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

endmodule

// File: rtl/pkr_arb.sv
module pkr_arb
  import pkr_pkg::*;
(
  input  logic       a_vld,
  input  osel_e      a_sel,
  input  logic       b_vld,
  input  osel_e      b_sel,
  input  logic [1:0] room,
  output logic       a_go,
  output logic       b_go
);

  logic a_room, b_room, clash;

  always_comb begin
    a_room = (a_sel == SEL_O1) ? room[0] : room[1];
    b_room = (b_sel == SEL_O1) ? room[0] : room[1];
    clash  = a_vld && (a_sel == b_sel);
    a_go   = a_vld && a_room;
    b_go   = b_vld && b_room && !clash;
  end

endmodule

// File: rtl/pkr_hits.sv
module pkr_hits #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc0,
  input  logic          inc1,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = inc0 || inc1;

  always_comb begin
    cnt_d = count + CW'(inc0) + CW'(inc1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cnt_en) count <= cnt_d;
  end

  // R8: no increment request, no change
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

endmodule

// File: rtl/pkr_router.sv
module pkr_router
  import pkr_pkg::*;
#(
  parameter int PKT_W   = 16,
  parameter int DEPTH   = 4,
  parameter int CNT_W   = 16,
  parameter int DST_BIT = 0,
  parameter int HIT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  input  logic [PKT_W-1:0] a_data,
  output logic             a_ready,
  input  logic             b_valid,
  input  logic [PKT_W-1:0] b_data,
  output logic             b_ready,
  output logic             o1_valid,
  output logic [PKT_W-1:0] o1_data,
  input  logic             o1_ready,
  output logic             o2_valid,
  output logic [PKT_W-1:0] o2_data,
  input  logic             o2_ready,
  output logic [CNT_W-1:0] hit_count
);

  localparam int NOUT = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  osel_e             a_sel, b_sel;
  logic [NOUT-1:0]   full_w, room, push_w, vld_w, rdy_w;
  logic [PKT_W-1:0]  pdata [NOUT];
  logic [PKT_W-1:0]  odata [NOUT];
  logic              a_go, b_go;

  assign a_sel = pick_out(a_data[DST_BIT]);
  assign b_sel = pick_out(b_data[DST_BIT]);
  assign room  = ~full_w & {NOUT{rst_q}};
  assign rdy_w = {o2_ready, o1_ready};

  pkr_arb u_arb (
    .a_vld (a_valid),
    .a_sel (a_sel),
    .b_vld (b_valid),
    .b_sel (b_sel),
    .room  (room),
    .a_go  (a_go),
    .b_go  (b_go)
  );

  assign a_ready = a_go;
  assign b_ready = b_go;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    localparam osel_e MY_SEL = (g == 0) ? SEL_O1 : SEL_O2;
    logic a_here, b_here;

    assign a_here   = a_go && (a_sel == MY_SEL);
    assign b_here   = b_go && (b_sel == MY_SEL);
    assign push_w[g] = a_here || b_here;
    assign pdata[g]  = a_here ? a_data : b_data;

    pkr_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_q),
      .push      (push_w[g]),
      .push_data (pdata[g]),
      .full      (full_w[g]),
      .out_vld   (vld_w[g]),
      .out_data  (odata[g]),
      .out_rdy   (rdy_w[g])
    );
  end

  assign o1_valid = vld_w[0];
  assign o1_data  = odata[0];
  assign o2_valid = vld_w[1];
  assign o2_data  = odata[1];

  pkr_hits #(.CW(CNT_W)) u_hits (
    .clk   (clk),
    .rst_n (rst_q),
    .inc0  (a_go && a_data[HIT_BIT]),
    .inc1  (b_go && b_data[HIT_BIT]),
    .count (hit_count)
  );

  // R4: B loses a shared target to A
  a_r4_b_yields: assert property (@(posedge clk) disable iff (!rst_q)
    (a_valid && b_valid && (a_sel == b_sel)) |-> !b_ready);

  // R5: two grants in one cycle never meet at one output
  a_r5_split_targets: assert property (@(posedge clk) disable iff (!rst_q)
    (a_ready && b_ready) |-> (a_sel != b_sel));

  // R3: an accepted packet shows up at its output next cycle
  a_r3_lands_o1: assert property (@(posedge clk) disable iff (!rst_q)
    ((a_ready && a_sel == SEL_O1) || (b_ready && b_sel == SEL_O1)) |=> o1_valid);

  a_r3_lands_o2: assert property (@(posedge clk) disable iff (!rst_q)
    ((a_ready && a_sel == SEL_O2) || (b_ready && b_sel == SEL_O2)) |=> o2_valid);

  // R1: nothing accepted until reset is released internally
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_q |-> (!a_ready && !b_ready));

endmodule

// File: tb/pkr_router_bench.sv
`timescale 1ns/1ps
module pkr_router_bench;

  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_valid, b_valid, a_ready, b_ready;
  logic [15:0] a_data, b_data, o1_data, o2_data;
  logic        o1_valid, o2_valid, o1_ready, o2_ready;
  logic [CW-1:0] hit_count;

  always #5 clk = ~clk;

  pkr_router #(.CNT_W(CW)) u_pkr_router (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .o1_valid(o1_valid), .o1_data(o1_data), .o1_ready(o1_ready),
    .o2_valid(o2_valid), .o2_data(o2_data), .o2_ready(o2_ready),
    .hit_count(hit_count)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [15:0] refq [2][64];
  int          hd [2];
  int          tl [2];
  int          exp_cnt;
  bit          a_have, b_have;
  logic [15:0] a_pkt, b_pkt;
  int          na, nb;
  logic [15:0] lf;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int occ(input int k);
    return tl[k] - hd[k];
  endfunction

  // one cycle of stimulus and checking in the given phase
  task automatic step(input int mode, input int c);
    int  ia, ib;
    bit  ea, eb, want_a, want_b;
    bit  rdy [2];
    string ta, tb;
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    case (mode)
      0: begin rdy[0] = 1; rdy[1] = 1; end
      1: begin rdy[0] = 0; rdy[1] = 1; end
      2: begin rdy[0] = 1; rdy[1] = 0; end
      3: begin rdy[0] = (c >= 120); rdy[1] = (c >= 120); end
      default: begin rdy[0] = lf[3]; rdy[1] = lf[7]; end
    endcase
    want_a = (mode == 4) ? lf[1] : 1'b1;
    want_b = (mode == 4) ? lf[5] : (mode != 5);
    if (!a_have && want_a) begin
      a_pkt  = {1'b0, 13'(na), na[1], na[0]};
      a_have = 1; na++;
    end
    if (!b_have && want_b) begin
      b_pkt  = {1'b1, 13'(nb), nb[0] ^ nb[2], nb[1]};
      b_have = 1; nb++;
    end
    a_valid = a_have; a_data = a_have ? a_pkt : 16'h0;
    b_valid = b_have; b_data = b_have ? b_pkt : 16'h0;
    o1_ready = rdy[0]; o2_ready = rdy[1];
    #1;
    // output side against the reference queues (R9, R2, R8)
    chk("R9 o1_valid", o1_valid, occ(0) > 0);
    chk("R9 o2_valid", o2_valid, occ(1) > 0);
    if (occ(0) > 0) chk("R2 o1_data", o1_data, refq[0][hd[0] & 63]);
    if (occ(1) > 0) chk("R2 o2_data", o2_data, refq[1][hd[1] & 63]);
    chk("R8 hit_count", hit_count, exp_cnt[CW-1:0]);
    // expected grants: dest bit 1 -> queue index 0 (output 1)
    ia = a_pkt[0] ? 0 : 1;
    ib = b_pkt[0] ? 0 : 1;
    ea = a_have && (occ(ia) < 4);
    eb = b_have && (occ(ib) < 4) && !(a_have && ia == ib);
    ta = !a_have ? "R3 a_ready idle" : (occ(ia) >= 4 ? "R7 a_ready held" :
         (occ(1 - ia) >= 4 ? "R6 a_ready other full" : "R3 a_ready"));
    tb = !b_have ? "R3 b_ready idle" : ((a_have && ia == ib) ? "R4 b_ready clash" :
         (occ(ib) >= 4 ? "R7 b_ready held" :
         (a_have ? "R5 b_ready parallel" : "R3 b_ready")));
    chk(ta, a_ready, ea);
    chk(tb, b_ready, eb);
    // advance the reference to the state after the coming edge
    for (int k = 0; k < 2; k++)
      if (occ(k) > 0 && rdy[k]) hd[k]++;
    if (ea) begin
      refq[ia][tl[ia] & 63] = a_pkt; tl[ia]++;
      exp_cnt = exp_cnt + int'(a_pkt[1]);
      a_have = 0;
    end
    if (eb) begin
      refq[ib][tl[ib] & 63] = b_pkt; tl[ib]++;
      exp_cnt = exp_cnt + int'(b_pkt[1]);
      b_have = 0;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    a_valid = 1'b1; a_data = 16'h0003;
    b_valid = 1'b1; b_data = 16'h0002;
    o1_ready = 1'b1; o2_ready = 1'b1;
    hd[0] = 0; hd[1] = 0; tl[0] = 0; tl[1] = 0;
    exp_cnt = 0; a_have = 0; b_have = 0; na = 0; nb = 0;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state, inputs valid but refused
    chk("R1 o1_valid", o1_valid, 0);
    chk("R1 o2_valid", o2_valid, 0);
    chk("R1 hit_count", hit_count, 0);
    chk("R1 a_ready", a_ready, 0);
    chk("R1 b_ready", b_ready, 0);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 o1_valid after release", o1_valid, 0);
    chk("R1 hit_count after release", hit_count, 0);
    repeat (2) @(posedge clk);
    // phase sweep over sink patterns and input patterns
    for (int m = 0; m < 6; m++)
      for (int c = 0; c < 240; c++)
        step(m, c);
    // drain with sinks open and inputs idle
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0; o1_ready = 1'b1; o2_ready = 1'b1;
      #1;
      if (c == 0) begin
        if (a_have) tl[0] = tl[0]; // pending packets are not in the block
      end
      chk("R9 drain o1_valid", o1_valid, occ(0) > 0);
      chk("R9 drain o2_valid", o2_valid, occ(1) > 0);
      if (occ(0) > 0) chk("R2 drain o1_data", o1_data, refq[0][hd[0] & 63]);
      if (occ(1) > 0) chk("R2 drain o2_data", o2_data, refq[1][hd[1] & 63]);
      chk("R8 drain hit_count", hit_count, exp_cnt[CW-1:0]);
      chk("R3 drain a_ready", a_ready, 0);
      for (int k = 0; k < 2; k++)
        if (occ(k) > 0) hd[k]++;
    end
    // R7: every accepted packet was delivered exactly once
    chk("R7 o1 all delivered", occ(0), 0);
    chk("R7 o2 all delivered", occ(1), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule